// File: doc/BRIEF.md
# Expansion Slot Address Decoder

This block is the address glue for an 8-bit processor system with a 16 KB banked ROM window at the top of memory. It holds the ROM bank register, which the processor writes at address $01 and can read back there. From the processor address and that register it drives one select for the onboard ROM, one ROM select for each of four expansion cards, and a shared set of card bank lines, so that each card sees its own 128 KB of banked space.

While bank bit 7 is clear, the window maps onto the 32 onboard banks. Setting bit 7 turns the onboard ROM off and hands the window to the card whose slot number equals bank bits 6:5. Each card receives bank bits 2:0 and never sees bits 4:3, so a card decodes its banks sparsely. The block also splits a 256-byte I/O page so that every slot has a private 32-byte select and a private 8-byte select. A slot therefore no longer needs jumpers to pick one of several shared selects.

Top module: `exp_slot_decoder`

## Requirements
- R1: After reset the bank register holds 0. A read at $01 returns 0, and an access with A15 = A14 = 1 selects the onboard ROM.
- R2: A cycle with wr_en high and addr = $01 loads wdata into the bank register at that rising clock edge. The new value is used from the next cycle onward. A write to any other address leaves the register unchanged.
- R3: rom_sel_n is low exactly when A15 = A14 = 1 and bank bit 7 is 0. Any of bank values 0 to 127 selects the onboard ROM.
- R4: While bank bit 7 is 1, rom_sel_n stays high for every address.
- R5: card_rom_sel_n[k] is low exactly when A15 = A14 = 1, bank bit 7 is 1 and bank bits 6:5 equal k.
- R6: card_bank always equals bank bits 2:0. Bank bits 4:3 affect no card select and no card bank line.
- R7: io_sel_n[k] is low exactly when addr[15:8] equals the I/O page (default $9F) and addr[7:5] equals 4 + k. Each such select covers 32 bytes.
- R8: io_sub_sel_n[k] is low exactly when addr[15:8] equals the I/O page, addr[7:5] = 3 and addr[4:3] = k. Each such select covers 8 bytes.
- R9: In any cycle, at most one of rom_sel_n and card_rom_sel_n is low. Likewise, at most one of io_sel_n and io_sub_sel_n is low.
- R10: rdata equals the bank register when addr = $01 and is 0 at every other address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 16 | Processor address bus |
| wr_en | input | 1 | Write strobe for the current cycle |
| wdata | input | 8 | Write data for the bank register |
| rdata | output | 8 | Bank register readback at $01, otherwise 0 |
| rom_sel_n | output | 1 | Onboard ROM select, active low |
| card_rom_sel_n | output | 4 | Per-card ROM selects, active low, index is slot number |
| card_bank | output | 3 | Bank lines shared by all cards |
| io_sel_n | output | 4 | Per-slot 32-byte I/O selects, active low |
| io_sub_sel_n | output | 4 | Per-slot 8-byte I/O selects, active low |

## Verification
The bench builds the decoder with its default parameters: an I/O page of $9F, the bank register at $01, three card bank lines, slot selects that start at group 4 and the shared 8-byte group at 3. With these values every I/O group boundary can be reached in the $9F00 to $9FFF page. Random bank values cover all four slot fields, both states of the external bit and every value of the ignored bits 4:3. A directed sequence writes $98 and $80 to show sparse decoding, writes $E5 to select slot 3, and writes to addresses next to $01 to show those writes are ignored.

// File: rtl/exp_dec_pkg.sv
package exp_dec_pkg;
  localparam int ADDR_W    = 16;
  localparam int BANK_W    = 8;
  localparam int SLOT_BITS = 2;
  localparam int SLOT_CNT  = 1 << SLOT_BITS;
  localparam int EXT_BIT   = BANK_W - 1;
  localparam int GRP_LSB   = 5;
  localparam int GRP_W     = 3;
  localparam int SUB_LSB   = 3;
  localparam int PAGE_LSB  = GRP_LSB + GRP_W;

  typedef logic [BANK_W-1:0] bank_t;

  function automatic logic rom_window(input logic [1:0] top_bits);
    return top_bits[1] & top_bits[0];
  endfunction

  function automatic logic [SLOT_BITS-1:0] slot_field(input bank_t b);
    return b[EXT_BIT-1 -: SLOT_BITS];
  endfunction
endpackage

// File: rtl/exp_bank_reg.sv
module exp_bank_reg import exp_dec_pkg::*; #(
  parameter logic [ADDR_W-1:0] BANK_ADDR = 16'h0001
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [BANK_W-1:0] wdata,
  output bank_t             bank_q,
  output logic [BANK_W-1:0] rdata
);
  logic reg_hit;
  logic bank_wr_hit;

  assign reg_hit     = (addr == BANK_ADDR);
  assign bank_wr_hit = reg_hit & wr_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           bank_q <= '0;
    else if (bank_wr_hit) bank_q <= wdata;
  end

  assign rdata = reg_hit ? bank_q : '0;

  // R2
  bank_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == BANK_ADDR) |=> bank_q == $past(wdata));
  // R2
  bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == BANK_ADDR) |=> $stable(bank_q));
endmodule

// File: rtl/exp_rom_decode.sv
module exp_rom_decode import exp_dec_pkg::*; #(
  parameter int CARD_BANK_W = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [1:0]             addr_top,
  input  logic                   ext_bit,
  input  logic [SLOT_BITS-1:0]   slot_sel,
  input  logic [CARD_BANK_W-1:0] bank_low,
  output logic                   rom_sel_n,
  output logic [SLOT_CNT-1:0]    card_sel_n,
  output logic [CARD_BANK_W-1:0] card_bank
);
  logic win_hit;
  logic onboard_hit;
  logic ext_hit;

  assign win_hit     = rom_window(addr_top);
  assign onboard_hit = win_hit & ~ext_bit;
  assign ext_hit     = win_hit & ext_bit;
  assign rom_sel_n   = ~onboard_hit;
  assign card_bank   = bank_low;

  for (genvar k = 0; k < SLOT_CNT; k++) begin : g_card
    assign card_sel_n[k] = ~(ext_hit & (slot_sel == SLOT_BITS'(k)));

    // R5
    card_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !card_sel_n[k] |-> (ext_bit && addr_top == 2'b11 && slot_sel == SLOT_BITS'(k)));
  end

  // R4
  onboard_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_bit |-> rom_sel_n);
  // R3
  onboard_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_bit && addr_top == 2'b11) |-> !rom_sel_n);
endmodule

// File: rtl/exp_io_decode.sv
module exp_io_decode import exp_dec_pkg::*; #(
  parameter logic [ADDR_W-PAGE_LSB-1:0] IO_PAGE = 8'h9F,
  parameter int FIRST_SEL  = 4,
  parameter int SHARED_SEL = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:SUB_LSB] addr_hi,
  output logic [SLOT_CNT-1:0]     io_sel_n,
  output logic [SLOT_CNT-1:0]     io_sub_sel_n
);
  logic                 page_hit;
  logic [GRP_W-1:0]     grp;
  logic [SLOT_BITS-1:0] sub;
  logic                 shared_hit;

  assign page_hit   = (addr_hi[ADDR_W-1:PAGE_LSB] == IO_PAGE);
  assign grp        = addr_hi[PAGE_LSB-1:GRP_LSB];
  assign sub        = addr_hi[GRP_LSB-1:SUB_LSB];
  assign shared_hit = page_hit & (grp == GRP_W'(SHARED_SEL));

  for (genvar k = 0; k < SLOT_CNT; k++) begin : g_slot
    assign io_sel_n[k]     = ~(page_hit & (grp == GRP_W'(FIRST_SEL + k)));
    assign io_sub_sel_n[k] = ~(shared_hit & (sub == SLOT_BITS'(k)));

    // R7
    io_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !io_sel_n[k] |-> addr_hi[ADDR_W-1:PAGE_LSB] == IO_PAGE);
    // R8
    io_sub_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !io_sub_sel_n[k] |-> (addr_hi[ADDR_W-1:PAGE_LSB] == IO_PAGE && grp == GRP_W'(SHARED_SEL)));
  end
endmodule

// File: rtl/exp_slot_decoder.sv
module exp_slot_decoder import exp_dec_pkg::*; #(
  parameter logic [ADDR_W-1:0]          BANK_ADDR   = 16'h0001,
  parameter logic [ADDR_W-PAGE_LSB-1:0] IO_PAGE     = 8'h9F,
  parameter int                         CARD_BANK_W = 3,
  parameter int                         FIRST_SEL   = 4,
  parameter int                         SHARED_SEL  = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [ADDR_W-1:0]      addr,
  input  logic                   wr_en,
  input  logic [BANK_W-1:0]      wdata,
  output logic [BANK_W-1:0]      rdata,
  output logic                   rom_sel_n,
  output logic [SLOT_CNT-1:0]    card_rom_sel_n,
  output logic [CARD_BANK_W-1:0] card_bank,
  output logic [SLOT_CNT-1:0]    io_sel_n,
  output logic [SLOT_CNT-1:0]    io_sub_sel_n
);
  bank_t bank_q;

  exp_bank_reg #(.BANK_ADDR(BANK_ADDR)) u_bank (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
    .wdata(wdata), .bank_q(bank_q), .rdata(rdata)
  );

  exp_rom_decode #(.CARD_BANK_W(CARD_BANK_W)) u_rom (
    .clk(clk), .rst_n(rst_n),
    .addr_top(addr[ADDR_W-1 -: 2]),
    .ext_bit(bank_q[EXT_BIT]),
    .slot_sel(slot_field(bank_q)),
    .bank_low(bank_q[CARD_BANK_W-1:0]),
    .rom_sel_n(rom_sel_n),
    .card_sel_n(card_rom_sel_n),
    .card_bank(card_bank)
  );

  exp_io_decode #(.IO_PAGE(IO_PAGE), .FIRST_SEL(FIRST_SEL), .SHARED_SEL(SHARED_SEL)) u_io (
    .clk(clk), .rst_n(rst_n),
    .addr_hi(addr[ADDR_W-1:SUB_LSB]),
    .io_sel_n(io_sel_n),
    .io_sub_sel_n(io_sub_sel_n)
  );

  // R9
  rom_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({~rom_sel_n, ~card_rom_sel_n}) <= 1);
  // R9
  io_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({~io_sel_n, ~io_sub_sel_n}) <= 1);
  // R6
  card_bank_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == BANK_ADDR) |=> card_bank == $past(wdata[CARD_BANK_W-1:0]));
endmodule

// File: tb/exp_slot_decoder_bench.sv
`timescale 1ns/1ps
module exp_slot_decoder_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = 16'h0000;
  logic        wr_en = 1'b0;
  logic [7:0]  wdata = 8'h00;
  logic [7:0]  rdata;
  logic        rom_sel_n;
  logic [3:0]  card_rom_sel_n, io_sel_n, io_sub_sel_n;
  logic [2:0]  card_bank;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [7:0] model_bank = 8'h00;

  always #2.5 clk = ~clk;

  exp_slot_decoder u_exp_slot_decoder (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
    .rdata(rdata), .rom_sel_n(rom_sel_n), .card_rom_sel_n(card_rom_sel_n),
    .card_bank(card_bank), .io_sel_n(io_sel_n), .io_sub_sel_n(io_sub_sel_n)
  );

  function automatic logic exp_rom(input logic [15:0] a, input logic [7:0] b);
    return !(a[15] && a[14] && !b[7]);
  endfunction

  function automatic logic [3:0] exp_card(input logic [15:0] a, input logic [7:0] b);
    logic [3:0] v = 4'hF;
    if (a[15:14] == 2'b11 && b[7]) v[b[6:5]] = 1'b0;
    return v;
  endfunction

  function automatic logic [3:0] exp_io(input logic [15:0] a);
    logic [3:0] v = 4'hF;
    int g = int'(a[7:5]);
    if (a[15:8] == 8'h9F && g >= 4) v[g-4] = 1'b0;
    return v;
  endfunction

  function automatic logic [3:0] exp_sub(input logic [15:0] a);
    logic [3:0] v = 4'hF;
    if (a[15:8] == 8'h9F && a[7:5] == 3'd3) v[a[4:3]] = 1'b0;
    return v;
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s addr=%h bank=%h actual=%h expected=%h", tag, addr, model_bank, act, exp);
    end
  endtask

  task automatic check_all();
    chk(model_bank[7] ? "R4 onboard off" : "R3 onboard select", {7'd0, rom_sel_n}, {7'd0, exp_rom(addr, model_bank)});
    chk("R5 card select", {4'd0, card_rom_sel_n}, {4'd0, exp_card(addr, model_bank)});
    chk("R6 card bank", {5'd0, card_bank}, {5'd0, model_bank[2:0]});
    chk("R7 io 32-byte", {4'd0, io_sel_n}, {4'd0, exp_io(addr)});
    chk("R8 io 8-byte", {4'd0, io_sub_sel_n}, {4'd0, exp_sub(addr)});
    chk("R9 rom exclusive", {7'd0, $countones({~rom_sel_n, ~card_rom_sel_n}) <= 1}, 8'd1);
    chk("R9 io exclusive", {7'd0, $countones({~io_sel_n, ~io_sub_sel_n}) <= 1}, 8'd1);
    chk("R10 readback", rdata, (addr == 16'h0001) ? model_bank : 8'h00);
  endtask

  task automatic access(input logic [15:0] a, input logic we, input logic [7:0] d);
    @(negedge clk);
    addr = a; wr_en = we; wdata = d;
    #1;
    check_all();
    if (we && a == 16'h0001) model_bank = d;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'hC0DE));
    repeat (3) @(negedge clk);
    addr = 16'h0001;
    #1;
    chk("R1 reset readback", rdata, 8'h00);
    rst_n = 1'b1;
    addr = 16'hC000;
    #1;
    chk("R1 reset onboard", {7'd0, rom_sel_n}, 8'd0);

    // R2: writes near $01 are ignored
    access(16'h0000, 1'b1, 8'hFF);
    access(16'h0002, 1'b1, 8'hFF);
    access(16'h0001, 1'b0, 8'h00);
    chk("R2 stray write ignored", rdata, 8'h00);
    // R6: sparse decoding, bits 4:3 do not matter
    access(16'h0001, 1'b1, 8'h98);
    access(16'hC123, 1'b0, 8'h00);
    chk("R6 sparse card0", {4'd0, card_rom_sel_n}, 8'h0E);
    access(16'h0001, 1'b1, 8'h80);
    access(16'hFFFF, 1'b0, 8'h00);
    chk("R6 sparse same card", {4'd0, card_rom_sel_n}, 8'h0E);
    // R5: slot 3 with bank 5
    access(16'h0001, 1'b1, 8'hE5);
    access(16'hC000, 1'b0, 8'h00);
    chk("R5 slot3", {4'd0, card_rom_sel_n}, 8'h07);
    chk("R4 onboard off slot3", {7'd0, rom_sel_n}, 8'd1);
    access(16'hBFFF, 1'b0, 8'h00);
    access(16'h0001, 1'b1, 8'h1F);
    access(16'hC000, 1'b0, 8'h00);
    // I/O group boundaries
    for (int i = 0; i < 32; i++) access(16'h9F00 + 16'(i * 8), 1'b0, 8'h00);
    access(16'h9EFF, 1'b0, 8'h00);
    access(16'hA000, 1'b0, 8'h00);

    for (int n = 0; n < 2000; n++) begin
      logic [15:0] a;
      case ($urandom % 4)
        0: a = {2'b11, 14'($urandom)};
        1: a = {8'h9F, 8'($urandom)};
        2: a = 16'h0001;
        default: a = 16'($urandom);
      endcase
      access(a, ($urandom % 3) == 0, 8'($urandom));
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule